// File: doc/BRIEF.md
# Random Allocation Tag Generator

This block picks a 4-bit memory-safety tag for a pointer and writes that tag into the pointer's upper byte. It keeps a small state word that holds a 16-bit pseudo-random seed and the last tag it issued. On each request it steps a tapped shift register four times, takes one bit from each step to form a 4-bit offset, and then walks around the 16 tag values, starting from the stored tag and skipping every value named in the exclusion mask. The tag it lands on becomes the new tag.

The exclusion mask is the bitwise OR of two 16-bit inputs: one that comes with the request and one from a control setting. A seed of zero does not move, so when the reseed enable is set and the stored seed is zero, the block first loads a non-zero seed from an entropy input. The stepped seed and the chosen tag are held for the next request and are visible on the state output.

Top module: `rand_tag_gen`

## Requirements
- R1: After reset, `state_o` is zero, `done_o` is low and `ptr_o` is zero.
- R2: Tag value t is excluded when bit t of `op_excl_i | ctrl_excl_i` is set. Both inputs count equally.
- R3: Each request steps the seed four times. One step computes fb = s[5]^s[3]^s[2]^s[0] and then s = {fb, s[15:1]}. Offset bit i (bit 0 is the least significant) equals bit 0 of the seed after step i, counting from step 0.
- R4: The search starts at the stored tag. It first advances, wrapping modulo 16, until it reaches a tag that is not excluded. It then moves to the next tag that is not excluded, once for each count of the offset. The tag it ends on is the result.
- R5: When all 16 bits of the effective exclusion mask are set, the result tag is 0 and the seed is still stepped.
- R6: When the stored seed is zero and `reseed_en_i` is 1, the seed is replaced before stepping by `entropy_i`, or by 16'h0001 if `entropy_i` is zero. In every other case `entropy_i` has no effect.
- R7: `state_o` holds the result tag in bits [3:0] and the stepped seed in bits [23:8]. Bits [7:4] read as zero. The state changes only in the cycle after a request.
- R8: `ptr_o` equals the requesting `ptr_i` with bits [59:56] replaced by the result tag. All other bits are passed through unchanged.
- R9: `done_o` is high for exactly the one cycle after each request cycle, and the result appears on `ptr_o` and `state_o` in that same cycle. `ptr_o` holds its value while there are no requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, one tag per cycle in which it is high |
| op_excl_i | input | 16 | Exclusion mask supplied with the request |
| ctrl_excl_i | input | 16 | Exclusion mask from the control setting |
| reseed_en_i | input | 1 | Allows a zero seed to be replaced from entropy |
| entropy_i | input | 16 | Entropy word used for reseeding |
| ptr_i | input | 64 | Pointer to be tagged |
| ptr_o | output | 64 | Pointer with the new tag inserted |
| done_o | output | 1 | High for one cycle when a result is valid |
| state_o | output | 24 | Updated state word: tag in [3:0], seed in [23:8] |

## Verification
The bench builds the block with its default parameters: a 4-bit tag at pointer bit 56, a 16-bit seed with taps 5, 3, 2 and 0, and four steps per request. With these values every offset from 0 to 15 and every one of the 65,536 mask patterns can be reached. Random masks are biased toward sparse and dense patterns, so the search wraps past bit 15 often and runs long skip chains. Directed cases cover the zero-seed paths, the all-excluded mask and a mask that permits only one tag.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
    localparam int unsigned TAG_W_DEF    = 4;
    localparam int unsigned SEED_W_DEF   = 16;
    localparam int unsigned PTR_W_DEF    = 64;
    localparam int unsigned TAG_LSB_DEF  = 56;
    localparam int unsigned STEPS_DEF    = 4;
    localparam int unsigned SEED_LSB     = 8;
    localparam logic [15:0] TAPS_DEF     = 16'h002D;
    localparam logic [15:0] SEED_FALLBACK = 16'h0001;
endpackage

// File: rtl/rtg_lfsr.sv
module rtg_lfsr #(
    parameter int unsigned SEED_W = 16,
    parameter int unsigned STEPS  = 4,
    parameter logic [SEED_W-1:0] TAPS = 16'h002D
) (
    input  logic [SEED_W-1:0] seed_i,
    output logic [SEED_W-1:0] seed_o,
    output logic [STEPS-1:0]  offset_o
);
    logic [STEPS:0][SEED_W-1:0] chain;

    assign chain[0] = seed_i;

    for (genvar g = 0; g < STEPS; g++) begin : g_step
        assign chain[g+1]  = {^(chain[g] & TAPS), chain[g][SEED_W-1:1]};
        assign offset_o[g] = chain[g+1][0];
    end

    assign seed_o = chain[STEPS];
endmodule

// File: rtl/rtg_tag_search.sv
module rtg_tag_search #(
    parameter int unsigned TAG_W = 4,
    parameter int unsigned OFS_W = 4
) (
    input  logic [(1<<TAG_W)-1:0] excl_i,
    input  logic [TAG_W-1:0]      start_i,
    input  logic [OFS_W-1:0]      offset_i,
    output logic [TAG_W-1:0]      tag_o
);
    localparam int unsigned NTAGS  = 1 << TAG_W;
    localparam int unsigned NHOPS  = 1 << OFS_W;

    // First permitted tag at or after (tag + skip), wrapping.
    function automatic logic [TAG_W-1:0] next_ok(
        input logic [TAG_W-1:0] tag,
        input logic [NTAGS-1:0] excl,
        input logic             skip
    );
        logic [TAG_W-1:0] res;
        logic [TAG_W-1:0] cand;
        logic             found;
        res   = tag;
        found = 1'b0;
        for (int k = 0; k < NTAGS; k++) begin
            cand = tag + TAG_W'(k) + TAG_W'(skip);
            if (!found && !excl[cand]) begin
                res   = cand;
                found = 1'b1;
            end
        end
        return res;
    endfunction

    always_comb begin
        logic [TAG_W-1:0] t;
        if (&excl_i) begin
            t = '0;
        end else begin
            t = next_ok(start_i, excl_i, 1'b0);
            for (int s = 1; s < NHOPS; s++) begin
                if (s <= int'(offset_i)) t = next_ok(t, excl_i, 1'b1);
            end
        end
        tag_o = t;
    end
endmodule

// File: rtl/rand_tag_gen.sv
module rand_tag_gen
    import rtg_pkg::*;
#(
    parameter int unsigned TAG_W   = TAG_W_DEF,
    parameter int unsigned SEED_W  = SEED_W_DEF,
    parameter int unsigned PTR_W   = PTR_W_DEF,
    parameter int unsigned TAG_LSB = TAG_LSB_DEF,
    parameter int unsigned STEPS   = STEPS_DEF,
    parameter logic [SEED_W-1:0] TAPS = TAPS_DEF,
    localparam int unsigned NTAGS   = 1 << TAG_W,
    localparam int unsigned STATE_W = SEED_LSB + SEED_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic [NTAGS-1:0]   op_excl_i,
    input  logic [NTAGS-1:0]   ctrl_excl_i,
    input  logic               reseed_en_i,
    input  logic [SEED_W-1:0]  entropy_i,
    input  logic [PTR_W-1:0]   ptr_i,
    output logic [PTR_W-1:0]   ptr_o,
    output logic               done_o,
    output logic [STATE_W-1:0] state_o
);
    localparam int unsigned GAP_W = SEED_LSB - TAG_W;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [SEED_W-1:0] seed;
        logic [PTR_W-1:0]  ptr;
        logic              done;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [SEED_W-1:0] seed_src;
    logic [SEED_W-1:0] seed_next;
    logic [STEPS-1:0]  offset;
    logic [NTAGS-1:0]  excl_eff;
    logic [TAG_W-1:0]  tag_next;

    always_comb begin
        excl_eff = op_excl_i | ctrl_excl_i;
        seed_src = regs_q.seed;
        if (regs_q.seed == '0 && reseed_en_i) begin
            seed_src = (entropy_i == '0) ? SEED_W'(SEED_FALLBACK) : entropy_i;
        end
    end

    rtg_lfsr #(.SEED_W(SEED_W), .STEPS(STEPS), .TAPS(TAPS)) u_lfsr (
        .seed_i   (seed_src),
        .seed_o   (seed_next),
        .offset_o (offset)
    );

    rtg_tag_search #(.TAG_W(TAG_W), .OFS_W(STEPS)) u_search (
        .excl_i   (excl_eff),
        .start_i  (regs_q.tag),
        .offset_i (offset),
        .tag_o    (tag_next)
    );

    always_comb begin
        regs_d      = regs_q;
        regs_d.done = 1'b0;
        if (req_i) begin
            regs_d.tag  = tag_next;
            regs_d.seed = seed_next;
            regs_d.ptr  = ptr_i;
            regs_d.ptr[TAG_LSB +: TAG_W] = tag_next;
            regs_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign ptr_o   = regs_q.ptr;
    assign done_o  = regs_q.done;
    assign state_o = {regs_q.seed, {GAP_W{1'b0}}, regs_q.tag};

    // R9
    done_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> done_o);
    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !done_o);
    // R7
    state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> $stable(state_o));
    // R7
    state_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_o[SEED_LSB-1:TAG_W] == '0);
    // R5
    all_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && &(op_excl_i | ctrl_excl_i)) |=> state_o[TAG_W-1:0] == '0);
    // R4
    tag_permitted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !(&(op_excl_i | ctrl_excl_i)))
        |=> !$past(op_excl_i | ctrl_excl_i)[state_o[TAG_W-1:0]]);
    // R8
    ptr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> ptr_o[TAG_LSB-1:0] == $past(ptr_i[TAG_LSB-1:0]));
    // R8
    ptr_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> ptr_o[TAG_LSB +: TAG_W] == state_o[TAG_W-1:0]);
endmodule

// File: tb/tb_rand_tag_gen.sv
module tb_rand_tag_gen;
    localparam real CLK_NS = 4.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [15:0] op_excl_i = '0;
    logic [15:0] ctrl_excl_i = '0;
    logic        reseed_en_i = 1'b0;
    logic [15:0] entropy_i = '0;
    logic [63:0] ptr_i = '0;
    logic [63:0] ptr_o;
    logic        done_o;
    logic [23:0] state_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [15:0] m_seed = '0;
    logic [3:0]  m_tag  = '0;
    logic [63:0] m_ptr  = '0;

    rand_tag_gen dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i),
        .op_excl_i(op_excl_i), .ctrl_excl_i(ctrl_excl_i),
        .reseed_en_i(reseed_en_i), .entropy_i(entropy_i),
        .ptr_i(ptr_i), .ptr_o(ptr_o), .done_o(done_o), .state_o(state_o)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] pick(input logic [3:0] start, input int ofs, input logic [15:0] excl);
        logic [3:0] t;
        if (excl == 16'hFFFF) return 4'd0;
        t = start;
        while (excl[t]) t = t + 4'd1;
        for (int n = ofs; n > 0; n--) begin
            t = t + 4'd1;
            while (excl[t]) t = t + 4'd1;
        end
        return t;
    endfunction

    task automatic model(input logic [15:0] op, input logic [15:0] ctl, input logic ren,
                         input logic [15:0] ent, input logic [63:0] p);
        logic [15:0] s;
        int ofs;
        s = m_seed;
        if (s == 16'h0 && ren) s = (ent == 16'h0) ? 16'h0001 : ent;
        ofs = 0;
        for (int i = 0; i < 4; i++) begin
            s = {s[5] ^ s[3] ^ s[2] ^ s[0], s[15:1]};
            ofs = ofs | (int'(s[0]) << i);
        end
        m_seed = s;
        m_tag  = pick(m_tag, ofs, op | ctl);
        m_ptr  = p;
        m_ptr[59:56] = m_tag;
    endtask

    task automatic do_req(input logic [15:0] op, input logic [15:0] ctl, input logic ren,
                          input logic [15:0] ent, input logic [63:0] p, input string tagname);
        @(negedge clk);
        req_i = 1'b1; op_excl_i = op; ctrl_excl_i = ctl;
        reseed_en_i = ren; entropy_i = ent; ptr_i = p;
        model(op, ctl, ren, ent, p);
        @(negedge clk);
        req_i = 1'b0;
        check({tagname, " R3/R4/R7 state"}, 64'(state_o), 64'({m_seed, 4'h0, m_tag}));
        check("R8 pointer", ptr_o, m_ptr);
        check("R9 done high", 64'(done_o), 64'd1);
    endtask

    task automatic idle_check();
        @(negedge clk);
        ptr_i = ~ptr_i; entropy_i = 16'h5A5A; reseed_en_i = 1'b1;
        @(negedge clk);
        check("R9 done low", 64'(done_o), 64'd0);
        check("R7 state held", 64'(state_o), 64'({m_seed, 4'h0, m_tag}));
        check("R9 ptr held", ptr_o, m_ptr);
    endtask

    initial begin : watchdog
        #(CLK_NS * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] op, ctl;
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        check("R1 state", 64'(state_o), 64'd0);
        check("R1 done", 64'(done_o), 64'd0);
        check("R1 ptr", ptr_o, 64'd0);
        rst_n = 1'b1;
        // R3: zero seed without reseed stays zero, offset 0, first permitted tag
        do_req(16'h0003, 16'h0000, 1'b0, 16'hBEEF, 64'h0123_4567_89AB_CDEF, "R3 zero seed");
        check("R3 tag first permitted", 64'(state_o[3:0]), 64'd2);
        // R6: reseed with zero entropy uses fallback
        do_req(16'h0000, 16'h0000, 1'b1, 16'h0000, 64'hFFFF_FFFF_FFFF_FFFF, "R6 fallback");
        // R6: entropy ignored once seed non-zero
        do_req(16'h0000, 16'h0F00, 1'b1, 16'hACE1, 64'h0, "R6 ignore entropy");
        idle_check();
        // R5: all excluded through the two masks combined (R2)
        do_req(16'hFF00, 16'h00FF, 1'b0, 16'h0, 64'hA5A5_A5A5_A5A5_A5A5, "R5 all excluded R2");
        check("R5 tag zero", 64'(state_o[3:0]), 64'd0);
        // R4: only tag 15 permitted, forces wrap
        do_req(16'h7FFF, 16'h0000, 1'b0, 16'h0, 64'h1111_2222_3333_4444, "R4 single permitted");
        check("R4 tag 15", 64'(state_o[3:0]), 64'd15);
        do_req(16'h0000, 16'h3FFF, 1'b0, 16'h0, 64'h0, "R4 R2 ctrl only");
        idle_check();
        for (int i = 0; i < 400; i++) begin
            case ($urandom_range(3))
                0: begin op = 16'($urandom); ctl = 16'h0; end
                1: begin op = 16'h0; ctl = 16'($urandom); end
                2: begin op = 16'($urandom) | 16'($urandom); ctl = 16'($urandom) | 16'($urandom); end
                default: begin op = 16'($urandom) & 16'($urandom); ctl = 16'($urandom) & 16'($urandom); end
            endcase
            do_req(op, ctl, 1'($urandom), 16'($urandom), {$urandom, $urandom}, "R2 random");
            if ((i % 50) == 0) idle_check();
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule